// File: doc/BRIEF.md
# Three-wire serial register port

This block is the slave side of a serial configuration port. An external host reaches a bank of 8-bit registers through five signals: a serial clock, one shared bidirectional data line, an address strobe, an active-low chip select and a read/write select. A transfer is sixteen serial clocks long. The first eight bits, sent while the strobe is high, name the register. The last eight bits either carry write data from the host or carry the register's contents back to the host.

The host changes its outputs on the falling serial clock edge and also samples read data on the falling edge. The block samples on the rising edge and updates the bit it drives just after the rising edge. A completed write is carried into the core clock domain by a toggle flag and a synchronizer, and only then updates the register. The low registers are read/write configuration bytes, which are visible to the core as a flat output bus. The upper implemented registers are read-only and show core status inputs. Addresses above the implemented range read as zero.

Top module: `serial_reg_port`

## Requirements
- R1: After reset every read/write register holds 0x00 and `cfg_o` is all zero.
- R2: A frame is 16 rising serial clock edges: 8 address bits and then 8 data bits, each sent MSB first. A write frame (read/write select low at the 8th edge) stores its data byte in register index addr[7:2]. `cfg_o[8*i +: 8]` is register i. The store is visible on `cfg_o` from the 3rd rising core clock edge after the 16th serial edge and not before.
- R3: Address bits 1 and 0 are ignored. Addresses that differ only in those bits select the same register.
- R4: In a read frame the block drives the selected register onto the data line MSB first. Bit 7 is valid after the 8th rising edge, and each later rising edge moves on to the next lower bit. The line is released after the 16th edge and at all times outside a read data phase.
- R5: Indices RO_BASE..NUM_REGS-1 (48..56 by default) are read-only. Writes to them change no register. Reads return `status_i[8*(i-RO_BASE) +: 8]`.
- R6: Reads of unimplemented indices (57..63 by default) return 0x00.
- R7: If chip select goes high before the 16th edge, the frame is aborted. No register changes, and the next frame starts again from address bit 7.
- R8: Rising serial edges at the start of a frame while the address strobe is low are ignored and do not count as address bits.
- R9: The read/write select is sampled at the 8th rising edge. High means read and low means write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Chip select, active low |
| as_i | input | 1 | Address strobe, high during address bits |
| rw_i | input | 1 | Read/write select, high = read |
| sd_io | inout | 1 | Bidirectional serial data line |
| status_i | input | 8*(NUM_REGS-RO_BASE) | Values of the read-only registers |
| cfg_o | output | 8*RO_BASE | Contents of the read/write registers |

## Verification
Read data bit 7-k is due just after rising serial edge 8+k. The bench samples it in the middle of the high phase, before the host's falling-edge capture point. A write reaches `cfg_o` on the third core edge after the last serial rising edge. The bench checks `cfg_o` 1 ns after that serial edge, where it must still hold the old value, and again after the frame ends, by which point several core edges have passed. Core clock edges sit on half-nanosecond offsets, so no serial edge coincides with a core edge.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int CNT_W  = 4;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/srp_shift.sv
module srp_shift
  import srp_pkg::*;
(
  input  logic  sclk_i,
  input  logic  rst_ni,
  input  logic  cs_ni,
  input  logic  as_i,
  input  logic  rw_i,
  input  logic  sd_i,
  output logic  sd_o,
  output logic  sd_oe_o,
  output idx_t  rd_idx_o,
  input  byte_t rd_byte_i,
  output idx_t  wr_idx_o,
  output byte_t wr_data_o,
  output logic  wr_tog_o
);
  logic [CNT_W-1:0] cnt_q;
  byte_t sh_q;
  idx_t  idx_q;
  logic  rd_q;
  logic  idle_skip;
  logic  wr_done;

  assign idle_skip = (cnt_q == '0) && !as_i;
  assign wr_done   = (cnt_q == 4'd15) && !rd_q;
  // address bits 7:2 sit in sh_q[6:1] when the 8th bit arrives
  assign rd_idx_o  = sh_q[6:1];

  always_ff @(posedge sclk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      idx_q <= '0;
      rd_q  <= 1'b0;
    end else if (cs_ni) begin
      cnt_q <= '0;
      rd_q  <= 1'b0;
    end else if (!idle_skip) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == 4'd7) begin
        idx_q <= sh_q[6:1];
        rd_q  <= rw_i;
        sh_q  <= rw_i ? rd_byte_i : {sh_q[6:0], sd_i};
      end else begin
        sh_q <= {sh_q[6:0], sd_i};
      end
      if (cnt_q == 4'd15) rd_q <= 1'b0;
    end
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      wr_tog_o  <= 1'b0;
    end else if (!cs_ni && wr_done) begin
      wr_idx_o  <= idx_q;
      wr_data_o <= {sh_q[6:0], sd_i};
      wr_tog_o  <= !wr_tog_o;
    end
  end

  assign sd_o    = sh_q[7];
  assign sd_oe_o = rd_q && cnt_q[3] && !cs_ni;

  a_r9_read_drives: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (cnt_q == 4'd7 && rw_i) |=> sd_oe_o);
  a_r2_write_toggles: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (cnt_q == 4'd15 && !sd_oe_o) |=> (wr_tog_o != $past(wr_tog_o)));
  a_r4_released_after: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (cnt_q == 4'd15) |=> !sd_oe_o);
endmodule

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic pulse_o
);
  logic [STAGES-1:0] s_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= '0;
      last_q <= 1'b0;
    end else begin
      s_q    <= {s_q[STAGES-2:0], tog_i};
      last_q <= s_q[STAGES-1];
    end
  end

  assign pulse_o = s_q[STAGES-1] ^ last_q;

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/srp_bank.sv
module srp_bank
  import srp_pkg::*;
#(
  parameter int NUM_REGS = 57,
  parameter int RO_BASE  = 48
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  idx_t                              wr_idx_i,
  input  byte_t                             wr_data_i,
  input  idx_t                              rd_idx_i,
  output byte_t                             rd_byte_o,
  input  logic [DATA_W*(NUM_REGS-RO_BASE)-1:0] status_i,
  output logic [DATA_W*RO_BASE-1:0]         cfg_o
);
  localparam logic [IDX_W:0] RO_L  = RO_BASE[IDX_W:0];
  localparam logic [IDX_W:0] NUM_L = NUM_REGS[IDX_W:0];

  byte_t cfg_q [RO_BASE];
  byte_t all_w [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < RO_BASE; k++) cfg_q[k] <= '0;
    end else if (wr_i && ({1'b0, wr_idx_i} < RO_L)) begin
      cfg_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g < RO_BASE) begin : g_rw
      assign all_w[g] = cfg_q[g];
      assign cfg_o[g*DATA_W +: DATA_W] = cfg_q[g];
    end else begin : g_ro
      assign all_w[g] = status_i[(g-RO_BASE)*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    rd_byte_o = '0;
    if ({1'b0, rd_idx_i} < NUM_L) rd_byte_o = all_w[rd_idx_i];
  end

  a_r2_no_stray_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_o));
  a_r5_ro_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ({1'b0, wr_idx_i} >= RO_L)) |=> $stable(cfg_o));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int NUM_REGS    = 57,
  parameter int RO_BASE     = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 sclk_i,
  input  logic                                 cs_ni,
  input  logic                                 as_i,
  input  logic                                 rw_i,
  inout  wire                                  sd_io,
  input  logic [DATA_W*(NUM_REGS-RO_BASE)-1:0] status_i,
  output logic [DATA_W*RO_BASE-1:0]            cfg_o
);
  logic  sd_o, sd_oe, wr_tog, wr_pulse;
  idx_t  rd_idx, wr_idx;
  byte_t rd_byte, wr_data;

  assign sd_io = sd_oe ? sd_o : 1'bz;

  srp_shift u_shift (
    .sclk_i    (sclk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .as_i      (as_i),
    .rw_i      (rw_i),
    .sd_i      (sd_io),
    .sd_o      (sd_o),
    .sd_oe_o   (sd_oe),
    .rd_idx_o  (rd_idx),
    .rd_byte_i (rd_byte),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .wr_tog_o  (wr_tog)
  );

  srp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tog_i   (wr_tog),
    .pulse_o (wr_pulse)
  );

  srp_bank #(.NUM_REGS(NUM_REGS), .RO_BASE(RO_BASE)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_pulse),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_byte_o (rd_byte),
    .status_i  (status_i),
    .cfg_o     (cfg_o)
  );

  always_comb begin
    if (!rst_ni) a_r1_released_in_reset: assert (!sd_oe);
  end
endmodule

// File: tb/serial_reg_port_test.sv
`timescale 1ns/100ps
module serial_reg_port_test;
  localparam int NR = 57;
  localparam int RB = 48;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, as = 1'b0, rw = 1'b0;
  logic host_oe = 1'b0, host_bit = 1'b0;
  wire  sd;
  logic [8*(NR-RB)-1:0] status;
  logic [8*RB-1:0]      cfg;
  logic [8*RB-1:0]      model;
  int checks = 0, errors = 0;
  bit done = 0;

  assign sd = host_oe ? host_bit : 1'bz;
  always #2.5 clk = ~clk;

  serial_reg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .as_i(as),
    .rw_i(rw), .sd_io(sd), .status_i(status), .cfg_o(cfg)
  );

  // {rw, addr, data, expected read}
  localparam logic [24:0] VEC [12] = '{
    {1'b0, 8'h00, 8'h55, 8'h00}, {1'b1, 8'h00, 8'h00, 8'h55},
    {1'b0, 8'h07, 8'hC3, 8'h00}, {1'b1, 8'h04, 8'h00, 8'hC3},
    {1'b0, 8'hBC, 8'h9A, 8'h00}, {1'b1, 8'hBF, 8'h00, 8'h9A},
    {1'b0, 8'hC0, 8'hFF, 8'h00}, {1'b1, 8'hC0, 8'h00, 8'hA0},
    {1'b1, 8'hE0, 8'h00, 8'hA8}, {1'b1, 8'hE4, 8'h00, 8'h00},
    {1'b1, 8'hFC, 8'h00, 8'h00}, {1'b0, 8'h01, 8'h01, 8'h00}
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_cfg(input string req);
    checks++;
    if (cfg !== model) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, cfg, model);
    end
  endtask

  // edges: number of rising edges before chip select returns high
  task automatic frame(input logic r, input logic [7:0] addr, input logic [7:0] wdata,
                       input int edges, input bit early_chk, output logic [7:0] rdata);
    logic [15:0] bits;
    bits = {addr, wdata};
    rdata = '0;
    cs_n = 1'b0;
    #25;
    for (int i = 0; i < edges; i++) begin
      as = (i < 8);
      rw = r;
      host_oe = (i < 8) || !r;
      host_bit = bits[15-i];
      #25 sclk = 1'b1;
      if (r && i == 7) host_oe = 1'b0;
      if (early_chk && i == 15) begin
        #1 check_cfg("R2 not before sync");
        #24;
      end else #25;
      if (r && i >= 7 && i <= 14) rdata[14-i] = sd;
      sclk = 1'b0;
    end
    #25 cs_n = 1'b1; host_oe = 1'b0; as = 1'b0;
    #100;
  endtask

  task automatic write_model(input logic [7:0] addr, input logic [7:0] d);
    if (addr[7:2] < RB) model[addr[7:2]*8 +: 8] = d;
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int k = 0; k < NR-RB; k++) status[k*8 +: 8] = 8'hA0 + 8'(k);
    model = '0;
    #20 rst_n = 1'b1;
    #20 check_cfg("R1 reset");

    // R2 R3 R4 R5 R6 R9 vector walk
    for (int v = 0; v < 12; v++) begin
      frame(VEC[v][24], VEC[v][23:16], VEC[v][15:8], 16, 1'b0, rd);
      if (VEC[v][24]) check8("R4/R3/R5/R6 read", rd, VEC[v][7:0]);
      else begin
        write_model(VEC[v][23:16], VEC[v][15:8]);
        check_cfg("R2/R5 write");
      end
    end

    // R2 latency: old value right after last edge, new value later
    frame(1'b0, 8'h08, 8'h3C, 16, 1'b1, rd);
    write_model(8'h08, 8'h3C);
    check_cfg("R2 after sync");

    // R7 abort mid data phase, then a clean frame
    frame(1'b0, 8'h0C, 8'hEE, 12, 1'b0, rd);
    check_cfg("R7 abort no update");
    frame(1'b1, 8'h0C, 8'h00, 5, 1'b0, rd);
    frame(1'b1, 8'h08, 8'h00, 16, 1'b0, rd);
    check8("R7 restart read", rd, 8'h3C);

    // R8 leading edges with strobe low are ignored
    cs_n = 1'b0; as = 1'b0; host_oe = 1'b1; host_bit = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #25 sclk = 1'b1; #25 sclk = 1'b0;
    end
    frame(1'b0, 8'h10, 8'h81, 16, 1'b0, rd);
    write_model(8'h10, 8'h81);
    check_cfg("R8 strobe low skipped");

    // R9 read with rw high leaves register untouched
    frame(1'b1, 8'h10, 8'h00, 16, 1'b0, rd);
    check8("R9 read value", rd, 8'h81);
    check_cfg("R9 read no write");

    // R1 reset clears written registers
    rst_n = 1'b0; #20 rst_n = 1'b1; #20;
    model = '0;
    check_cfg("R1 reset after writes");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule